// File: doc/BRIEF.md
# Master Data Width Splitter

This block sits on the master side of a 32-bit parallel system bus. It takes one local access of one to four contiguous bytes at a byte address. It finds out how wide the addressed slave's data port is and then runs as many bus data cycles as that port needs. Each cycle carries its bytes on the lanes the port expects, together with active-low byte enables, an active-low byte-high enable and one odd-parity bit per byte lane. On reads, the bytes that come back from each cycle are placed again at their original lane positions and returned as a single local result.

Bus timing is reduced to a handshake. The splitter pulses a start strobe and holds address, enables and data steady until the bus side pulses done. The slave reports its width on two active-low size lines, which the splitter samples in the cycle after it drives the request's address. The master does all data steering itself, so it keeps the bus translate request line low at all times. An illegal size code ends the request with an error and no data cycle is run.

Top module: `mws_splitter`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, bus_start is 0 and bus_xlat is 0.
- R2: When the size lines {bus_ds16_n, bus_ds32_n} read 00 (32-bit port), the splitter runs exactly one cycle. bus_addr is the request address. bus_be_n bit i is 0 exactly for each requested lane i. Write data keeps its lanes, with unrequested lanes driven to zero. bus_bhe_n is 0 when lane 1 or lane 3 carries data.
- R3: When the size lines read 01 (16-bit port), there is one cycle per halfword touched, lowest address first. Each cycle carries its bytes on lanes 0–1, with byte a[0] of the halfword on lane a[0]. bus_addr is the lowest byte of that cycle. bus_be_n marks lanes 0–1 as used. bus_bhe_n is 0 exactly when the odd byte of the halfword is present.
- R4: When the size lines read 11 (8-bit port), there is one cycle per requested byte in ascending address order. Each byte is on lane 0, with bus_be_n = 1110, bus_bhe_n = 1, and bus_addr equal to that byte's address.
- R5: On reads, each cycle's returned bus lanes are moved back to the requested byte positions of rsp_rdata. Lanes that were not requested read as zero.
- R6: During write cycles, bus_dpar[i] is the odd parity of bus_wdata byte i for each lane i.
- R7: On reads with par_en = 1, rsp_perr is 1 when any used lane of any cycle has bus_rpar[i] that is not the odd parity of its byte. With par_en = 0, rsp_perr is 0 and the data is unaffected.
- R8: Size code 10 ends the request with rsp_valid and rsp_err = 1 one cycle after sampling, and no bus_start is issued.
- R9: bus_xlat stays 0 throughout every request.
- R10: bus_start is high for one cycle per bus cycle. bus_addr, bus_be_n and bus_wdata do not change from bus_start until the bus_done that ends that cycle.
- R11: req_ready is 0 from the cycle after acceptance until the response. rsp_valid is a single-cycle pulse in the cycle after the last bus_done, and req_ready is 1 again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Splitter idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of first byte |
| req_size | input | 2 | Byte count minus one |
| req_wdata | input | 32 | Write data at lane positions of its address |
| rsp_valid | output | 1 | Request finished (one cycle) |
| rsp_rdata | output | 32 | Read result at original lane positions |
| rsp_err | output | 1 | Illegal port-size code seen |
| rsp_perr | output | 1 | Read data parity error seen |
| par_en | input | 1 | Enable read parity check |
| bus_start | output | 1 | Start strobe of one bus data cycle |
| bus_done | input | 1 | End of current bus data cycle |
| bus_write | output | 1 | Direction of the bus cycle |
| bus_addr | output | ADDR_W | Bus byte address of the cycle |
| bus_be_n | output | 4 | Active-low byte enables per lane |
| bus_bhe_n | output | 1 | Active-low byte-high enable |
| bus_wdata | output | 32 | Steered write data |
| bus_dpar | output | 4 | Odd parity per write lane |
| bus_rdata | input | 32 | Read data from slave |
| bus_rpar | input | 4 | Odd parity per read lane |
| bus_ds16_n | input | 1 | Active-low 16-bit port return |
| bus_ds32_n | input | 1 | Active-low 32-bit port return |
| bus_xlat | output | 1 | Translate request, held inactive |

## Verification
The bench builds the splitter with ADDR_W = 16. This keeps the address short enough that a small bench byte model covers every accessed location. The byte lanes stay at four, so every port width and all start offsets 0 to 3 are reachable. These include unaligned partial accesses that span two halfwords on a 16-bit port and a full word split into four byte cycles. The slave model waits a programmable number of cycles before done, so held-cycle stability is observed over several cycles. It can also corrupt returned parity to exercise the check both enabled and disabled.

// File: rtl/mws_pkg.sv
package mws_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 2;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  typedef enum logic [1:0] {PORT8 = 2'd0, PORT16 = 2'd1, PORT32 = 2'd2, PORTBAD = 2'd3} port_e;

  // size lines are active low: {16-bit return, 32-bit return}
  function automatic port_e decode_port(input logic ds16_n, input logic ds32_n);
    case ({ds16_n, ds32_n})
      2'b11:   return PORT8;
      2'b01:   return PORT16;
      2'b00:   return PORT32;
      default: return PORTBAD;
    endcase
  endfunction

  function automatic logic [LANES-1:0] req_lanes(input logic [LANE_W-1:0] first,
                                                 input logic [1:0] cnt_m1);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++)
      m[i] = (i >= int'(first)) && (i <= int'(first) + int'(cnt_m1));
    return m;
  endfunction

  function automatic logic [LANE_W-1:0] low_lane(input logic [LANES-1:0] m);
    logic [LANE_W-1:0] l;
    l = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (m[i]) l = LANE_W'(i);
    return l;
  endfunction

  function automatic logic [LANES-1:0] piece_lanes(input port_e p, input logic [LANES-1:0] rem);
    logic [LANE_W-1:0] l;
    l = low_lane(rem);
    case (p)
      PORT8:   return LANES'(1) << l;
      PORT16:  return rem & (l[1] ? 4'b1100 : 4'b0011);
      default: return rem;
    endcase
  endfunction

  function automatic logic [LANE_W-1:0] lane_shift(input port_e p, input logic [LANE_W-1:0] l);
    case (p)
      PORT8:   return l;
      PORT16:  return {l[1], 1'b0};
      default: return '0;
    endcase
  endfunction

  function automatic logic odd_par(input logic [BYTE_W-1:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/mws_steer.sv
module mws_steer import mws_pkg::*; (
  input  port_e             port,
  input  logic [LANES-1:0]  rem,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [LANES-1:0]  piece,
  output logic [LANES-1:0]  bus_lanes,
  output logic [LANE_W-1:0] first_lane,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [LANES-1:0]  bus_be_n,
  output logic              bus_bhe_n,
  output logic [DATA_W-1:0] rd_merged
);
  logic [LANE_W-1:0] shift;
  logic [4:0]        sh_bits;
  logic [DATA_W-1:0] piece_bits;

  assign first_lane = low_lane(rem);
  assign piece      = piece_lanes(port, rem);
  assign shift      = lane_shift(port, first_lane);
  assign sh_bits    = {shift, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : g_bits
    assign piece_bits[g*BYTE_W +: BYTE_W] = {BYTE_W{piece[g]}};
  end

  assign bus_lanes = piece >> shift;
  assign bus_be_n  = ~bus_lanes;
  assign bus_bhe_n = ~(bus_lanes[1] | bus_lanes[3]);
  assign bus_wdata = (wdata & piece_bits) >> sh_bits;
  assign rd_merged = (bus_rdata << sh_bits) & piece_bits;
endmodule

// File: rtl/mws_parity.sv
module mws_parity import mws_pkg::*; (
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [LANES-1:0]  bus_rpar,
  input  logic [LANES-1:0]  bus_lanes,
  input  logic              chk_en,
  output logic [LANES-1:0]  bus_dpar,
  output logic              rd_par_err
);
  logic [LANES-1:0] lane_bad;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign bus_dpar[g] = odd_par(bus_wdata[g*BYTE_W +: BYTE_W]);
    assign lane_bad[g] = bus_lanes[g] &
                         (bus_rpar[g] != odd_par(bus_rdata[g*BYTE_W +: BYTE_W]));
  end

  assign rd_par_err = chk_en & (|lane_bad);
endmodule

// File: rtl/mws_splitter.sv
module mws_splitter import mws_pkg::*; #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              rsp_perr,
  input  logic              par_en,
  output logic              bus_start,
  input  logic              bus_done,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_be_n,
  output logic              bus_bhe_n,
  output logic [31:0]       bus_wdata,
  output logic [3:0]        bus_dpar,
  input  logic [31:0]       bus_rdata,
  input  logic [3:0]        bus_rpar,
  input  logic              bus_ds16_n,
  input  logic              bus_ds32_n,
  output logic              bus_xlat
);
  localparam int WORD_W = ADDR_W - LANE_W;

  typedef enum logic [2:0] {ST_IDLE, ST_SIZE, ST_ISSUE, ST_WAIT, ST_RESP} state_e;

  state_e            state_q;
  logic [WORD_W-1:0] base_q;
  logic [LANES-1:0]  rem_q;
  logic              write_q, err_q, perr_q;
  logic [DATA_W-1:0] wdata_q, result_q;
  port_e             port_q, port_dec;

  logic [LANES-1:0]  piece, bus_lanes, rem_next;
  logic [LANE_W-1:0] first_lane;
  logic [DATA_W-1:0] rd_merged;
  logic              rd_par_err;

  // named events for the checker
  logic cyc_wait, bad_port_evt, last_done;

  mws_steer u_steer (
    .port(port_q), .rem(rem_q), .wdata(wdata_q), .bus_rdata(bus_rdata),
    .piece(piece), .bus_lanes(bus_lanes), .first_lane(first_lane),
    .bus_wdata(bus_wdata), .bus_be_n(bus_be_n), .bus_bhe_n(bus_bhe_n),
    .rd_merged(rd_merged)
  );

  mws_parity u_par (
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rpar(bus_rpar),
    .bus_lanes(bus_lanes), .chk_en(par_en), .bus_dpar(bus_dpar),
    .rd_par_err(rd_par_err)
  );

  assign port_dec     = decode_port(bus_ds16_n, bus_ds32_n);
  assign rem_next     = rem_q & ~piece;
  assign cyc_wait     = (state_q == ST_WAIT);
  assign bad_port_evt = (state_q == ST_SIZE) && (port_dec == PORTBAD);
  assign last_done    = cyc_wait && bus_done && (rem_next == '0);

  assign req_ready = (state_q == ST_IDLE);
  assign bus_start = (state_q == ST_ISSUE);
  assign bus_write = write_q;
  assign bus_addr  = {base_q, first_lane};
  assign bus_xlat  = 1'b0;
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = result_q;
  assign rsp_err   = err_q;
  assign rsp_perr  = perr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      rem_q    <= '0;
      write_q  <= 1'b0;
      wdata_q  <= '0;
      result_q <= '0;
      err_q    <= 1'b0;
      perr_q   <= 1'b0;
      port_q   <= PORT32;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          base_q   <= req_addr[ADDR_W-1:LANE_W];
          rem_q    <= req_lanes(req_addr[LANE_W-1:0], req_size);
          write_q  <= req_write;
          wdata_q  <= req_wdata;
          result_q <= '0;
          err_q    <= 1'b0;
          perr_q   <= 1'b0;
          state_q  <= ST_SIZE;
        end
        ST_SIZE: begin
          port_q <= port_dec;
          if (port_dec == PORTBAD) begin
            err_q   <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (bus_done) begin
          rem_q <= rem_next;
          if (!write_q) begin
            result_q <= result_q | rd_merged;
            perr_q   <= perr_q | rd_par_err;
          end
          state_q <= (rem_next == '0) ? ST_RESP : ST_ISSUE;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mws_splitter_chk.sv
module mws_splitter_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_start,
  input logic              bus_done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be_n,
  input logic [31:0]       bus_wdata,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              req_ready,
  input logic              cyc_wait,
  input logic              bad_port_evt,
  input logic              last_done
);
  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start);

  // R10
  cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || (cyc_wait && !bus_done)) |=>
      ($stable(bus_addr) && $stable(bus_be_n) && $stable(bus_wdata)));

  // R8
  bad_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_port_evt |=> (rsp_valid && rsp_err && !bus_start));

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R11
  done_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_done |=> (rsp_valid && !rsp_err));

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> !req_ready);
endmodule

bind mws_splitter mws_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_done(bus_done),
  .bus_addr(bus_addr), .bus_be_n(bus_be_n), .bus_wdata(bus_wdata),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .req_ready(req_ready),
  .cyc_wait(cyc_wait), .bad_port_evt(bad_port_evt), .last_done(last_done)
);

// File: tb/sim_mws_splitter.sv
module sim_mws_splitter;
  localparam int AW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, par_en = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, rsp_perr;
  logic [31:0] rsp_rdata;
  logic bus_start, bus_write, bus_bhe_n, bus_xlat;
  logic bus_done = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [3:0] bus_be_n, bus_dpar;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic [3:0] bus_rpar = '0;
  logic bus_ds16_n = 1'b0, bus_ds32_n = 1'b0;

  always #10 clk = ~clk;

  mws_splitter #(.ADDR_W(AW)) u0 (.*);

  int nchk = 0, nfail = 0;
  int port_bytes = 4, rdelay = 1;
  bit corrupt = 0;
  int npc;
  logic [AW-1:0] lg_addr [8];
  logic [3:0]    lg_be   [8];
  logic          lg_bhe  [8];
  logic [31:0]   lg_wd   [8];
  logic [3:0]    lg_par  [8];
  logic          lg_wr   [8];
  logic          lg_x    [8];
  logic [31:0] r_data;
  logic r_err, r_perr;

  function automatic logic [7:0] memb(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic logic oddp(input logic [7:0] b);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(b[i]);
    return (c % 2 == 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // slave model: records each cycle, checks hold, returns data
  initial begin
    @(negedge clk);
    forever begin
      if (bus_start) begin
        int a;
        int base;
        logic [AW-1:0] ca; logic [3:0] cb; logic [31:0] cw;
        bit held = 1;
        ca = bus_addr; cb = bus_be_n; cw = bus_wdata;
        if (npc < 8) begin
          lg_addr[npc] = bus_addr; lg_be[npc] = bus_be_n; lg_bhe[npc] = bus_bhe_n;
          lg_wd[npc] = bus_wdata; lg_par[npc] = bus_dpar; lg_wr[npc] = bus_write;
          lg_x[npc] = bus_xlat;
        end
        npc++;
        for (int k = 0; k < rdelay; k++) begin
          @(negedge clk);
          if (k == 0) chk(bus_start == 1'b0, "R10 start strobe width", 32'(bus_start), 0);
          if (bus_addr != ca || bus_be_n != cb || bus_wdata != cw) held = 0;
        end
        chk(held, "R10 cycle outputs held", 32'(held), 1);
        a = int'(ca);
        base = a - (a % port_bytes);
        bus_rdata = '0; bus_rpar = '0;
        for (int k = 0; k < port_bytes; k++) begin
          bus_rdata[k*8 +: 8] = memb(base + k);
          bus_rpar[k] = oddp(memb(base + k));
        end
        if (corrupt) bus_rpar[0] = ~bus_rpar[0];
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic do_req(input bit wr, input int addr, input int szm1, input logic [31:0] wd,
                        input logic ds16, input logic ds32, input int pb);
    bit seen = 0;
    bus_ds16_n = ds16; bus_ds32_n = ds32; port_bytes = pb; npc = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(addr);
    req_size = 2'(szm1); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 busy after accept", 32'(req_ready), 0);
    for (int i = 0; i < 400 && !seen; i++) begin
      if (rsp_valid) begin
        seen = 1; r_data = rsp_rdata; r_err = rsp_err; r_perr = rsp_perr;
      end else @(negedge clk);
    end
    chk(seen, "R11 response seen", 32'(seen), 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R11 single response pulse",
        {30'b0, rsp_valid, req_ready}, 32'h1);
  endtask

  task automatic chk_piece(input int i, input int addr, input logic [3:0] be, input logic bhe,
                           input logic [31:0] wd, input bit wr, input string req);
    if (i >= npc) begin
      chk(0, req, 32'(npc), 32'(i + 1));
      return;
    end
    chk(lg_addr[i] == AW'(addr), req, 32'(lg_addr[i]), 32'(addr));
    chk(lg_be[i] == be, req, 32'(lg_be[i]), 32'(be));
    chk(lg_bhe[i] == bhe, req, 32'(lg_bhe[i]), 32'(bhe));
    chk(lg_wr[i] == wr, req, 32'(lg_wr[i]), 32'(wr));
    chk(lg_x[i] == 1'b0, "R9 translate low", 32'(lg_x[i]), 0);
    if (wr) begin
      logic [3:0] ep;
      for (int k = 0; k < 4; k++) ep[k] = oddp(wd[k*8 +: 8]);
      chk(lg_wd[i] == wd, req, lg_wd[i], wd);
      chk(lg_par[i] == ep, "R6 write parity", 32'(lg_par[i]), 32'(ep));
    end
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && bus_start == 1'b0 && bus_xlat == 1'b0,
        "R1 reset state", {28'b0, req_ready, rsp_valid, bus_start, bus_xlat}, 32'h8);
  endtask

  task automatic t_port32;
    do_req(1, 'h10, 3, 32'hA1B2C3D4, 0, 0, 4);
    chk(npc == 1, "R2 one cycle", 32'(npc), 1);
    chk_piece(0, 'h10, 4'b0000, 0, 32'hA1B2C3D4, 1, "R2 full word");
    do_req(1, 'h21, 1, 32'hFFBEEFFF, 0, 0, 4);
    chk(npc == 1, "R2 one cycle", 32'(npc), 1);
    chk_piece(0, 'h21, 4'b1001, 0, 32'h00BEEF00, 1, "R2 middle lanes");
  endtask

  task automatic t_port16;
    do_req(1, 'h30, 3, 32'h87654321, 0, 1, 2);
    chk(npc == 2, "R3 two halfwords", 32'(npc), 2);
    chk_piece(0, 'h30, 4'b1100, 0, 32'h00004321, 1, "R3 low half");
    chk_piece(1, 'h32, 4'b1100, 0, 32'h00008765, 1, "R3 high half");
    do_req(1, 'h41, 2, 32'hCCBBAA00, 0, 1, 2);
    chk(npc == 2, "R3 unaligned pieces", 32'(npc), 2);
    chk_piece(0, 'h41, 4'b1101, 0, 32'h0000AA00, 1, "R3 odd byte alone");
    chk_piece(1, 'h42, 4'b1100, 0, 32'h0000CCBB, 1, "R3 upper half");
    do_req(1, 'h44, 0, 32'h000000EE, 0, 1, 2);
    chk(npc == 1, "R3 single byte", 32'(npc), 1);
    chk_piece(0, 'h44, 4'b1110, 1, 32'h000000EE, 1, "R3 even byte bhe high");
  endtask

  task automatic t_port8;
    rdelay = 3;
    do_req(1, 'h50, 3, 32'h44332211, 1, 1, 1);
    chk(npc == 4, "R4 four byte cycles", 32'(npc), 4);
    chk_piece(0, 'h50, 4'b1110, 1, 32'h11, 1, "R4 byte0");
    chk_piece(1, 'h51, 4'b1110, 1, 32'h22, 1, "R4 byte1");
    chk_piece(2, 'h52, 4'b1110, 1, 32'h33, 1, "R4 byte2");
    chk_piece(3, 'h53, 4'b1110, 1, 32'h44, 1, "R4 byte3");
    rdelay = 1;
  endtask

  task automatic t_reads;
    logic [31:0] e;
    do_req(0, 'h60, 3, 0, 1, 1, 1);
    e = {memb('h63), memb('h62), memb('h61), memb('h60)};
    chk(npc == 4, "R4 read byte cycles", 32'(npc), 4);
    chk_piece(3, 'h63, 4'b1110, 1, 0, 0, "R4 read last byte");
    chk(r_data == e, "R5 read via 8-bit port", r_data, e);
    chk(r_perr == 1'b0, "R7 clean parity", 32'(r_perr), 0);
    do_req(0, 'h72, 1, 0, 0, 1, 2);
    e = {memb('h73), memb('h72), 16'h0};
    chk_piece(0, 'h72, 4'b1100, 0, 0, 0, "R3 read high half");
    chk(r_data == e, "R5 read via 16-bit port", r_data, e);
    do_req(0, 'h81, 2, 0, 0, 0, 4);
    e = {memb('h83), memb('h82), memb('h81), 8'h0};
    chk_piece(0, 'h81, 4'b0001, 0, 0, 0, "R2 read three bytes");
    chk(r_data == e, "R5 unrequested lane zero", r_data, e);
  endtask

  task automatic t_parity;
    corrupt = 1;
    par_en = 1'b1;
    do_req(0, 'h90, 0, 0, 1, 1, 1);
    chk(r_perr == 1'b1, "R7 bad parity flagged", 32'(r_perr), 1);
    par_en = 1'b0;
    do_req(0, 'h90, 0, 0, 1, 1, 1);
    chk(r_perr == 1'b0, "R7 check disabled", 32'(r_perr), 0);
    chk(r_data == {24'h0, memb('h90)}, "R7 data unaffected", r_data, {24'h0, memb('h90)});
    corrupt = 0;
    par_en = 1'b1;
  endtask

  task automatic t_badport;
    do_req(1, 'hA0, 3, 32'h12345678, 1, 0, 4);
    chk(r_err == 1'b1, "R8 error flag", 32'(r_err), 1);
    chk(npc == 0, "R8 no bus cycle", 32'(npc), 0);
    do_req(1, 'hA0, 0, 32'h5A, 0, 0, 4);
    chk(r_err == 1'b0 && npc == 1, "R8 recovery", {31'b0, r_err}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_port32;
    t_port16;
    t_port8;
    t_reads;
    t_parity;
    t_badport;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule